// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two N-bit unsigned operands (default N = 32) and returns a 2N-bit product. It trades speed for area: one N-bit adder is reused over N clock cycles instead of summing every partial product in parallel. A single 2N-bit accumulator holds the running result. When a start is accepted, its upper half is cleared and its lower half takes the multiplier. The multiplier bits are then consumed from the bottom, one per cycle, as the accumulator shifts right.

In each run cycle the accumulator's least significant bit decides whether the multiplicand is added to the upper half. If the bit is 0, the upper half passes through unchanged. In the same cycle the whole register shifts right by one. The adder's carry-out enters at the top, and the bit that falls off the bottom is discarded. The adder is a carry-lookahead design built from fixed-size groups.

Control is a three-state machine. ST_IDLE waits for start. The transition *accept* leads to ST_RUN, which holds for N cycles. The transition *finish* leads to ST_DONE, which lasts one cycle and raises done. From ST_DONE, the transition *restart* goes back to ST_RUN if start is present; otherwise *retire* returns to ST_IDLE. A user pulses start with both operands while busy is low, then reads the product in the cycle where done is high, or at any later time before the next start.

Top module: `shiftadd_mult`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, busy is 0, done is 0 and product is all zeros.
- R2: A start seen at a rising edge while busy is 0 is accepted. busy is 1 in the following cycle, and the operands present at that edge are the ones multiplied.
- R3: A start seen while busy is 1 is ignored. The run in progress keeps its operands and its timing.
- R4: After the accepting edge, busy stays 1 for exactly N cycles. done is then 1 for exactly one cycle, the cycle that follows the N-th rising edge after acceptance.
- R5: In the done cycle, product equals multiplicand × multiplier as a 2N-bit unsigned value.
- R6: While busy is 0 and no start is accepted, product does not change, so the result stays readable until the next accepted start.
- R7: Each run cycle adds the multiplicand into the upper half only when the accumulator's bit 0 is 1. The adder carry enters product bit 2N-1 as the register shifts right, so all-ones operands give (2^N-1)^2 with no lost carry.
- R8: Zero operands give a zero product, and an operand of 1 returns the other operand unchanged in the lower half with a zero upper half.
- R9: done and busy are never 1 together, and a start present in the done cycle is accepted, so back-to-back runs have no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiplication; sampled at the rising edge |
| multiplicand | input | N | Operand added into the upper half |
| multiplier | input | N | Operand loaded into the lower half and consumed by shifts |
| busy | output | 1 | 1 while the N run cycles are in progress |
| done | output | 1 | One-cycle pulse marking the product valid |
| product | output | 2N | Accumulator contents; final result from the done cycle on |

## Verification
The checker assumes that the operands are meaningful only at the accepting edge. It assumes no relation between start and the operands while busy is 1, and no minimum spacing between requests. The bench therefore changes the operand inputs freely in the cycles after acceptance. It also raises start in the middle of a run with different operands and in the done cycle itself, so both the ignored and the back-to-back case occur. Operands come from a seeded random generator, mixed with zero, one and all-ones values. This covers both the path where no add is made and the path where every cycle carries out of the adder.

// File: rtl/shiftadd_pkg.sv
`timescale 1ns/1ps
package shiftadd_pkg;

    // Control states of the iterative multiplier
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_t;

    // Width of a counter able to hold values 0 .. n-1
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/shiftadd_cla.sv
`timescale 1ns/1ps
// Carry-lookahead adder: full lookahead inside each group of GRP bits,
// group generate/propagate chained between groups.
module shiftadd_cla #(
    parameter int W   = 32,
    parameter int GRP = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NG = (W + GRP - 1) / GRP;
    localparam int WP = NG * GRP;

    logic [WP-1:0] xp, yp, bp, bg, sp;
    logic [NG:0]   gc;

    always_comb begin
        xp = '0;
        yp = '0;
        xp[W-1:0] = x;
        yp[W-1:0] = y;
    end

    assign bp    = xp ^ yp;
    assign bg    = xp & yp;
    assign gc[0] = cin;

    for (genvar gi = 0; gi < NG; gi++) begin : g_grp
        logic [GRP-1:0] pp, gg;
        logic [GRP:0]   cc;
        logic           grp_g, grp_p, run;

        assign pp = bp[gi*GRP +: GRP];
        assign gg = bg[gi*GRP +: GRP];

        always_comb begin
            run = 1'b0;
            for (int j = 0; j <= GRP; j++) begin
                cc[j] = gc[gi];
                for (int k = 0; k < j; k++) cc[j] = cc[j] & pp[k];
                for (int k = 0; k < j; k++) begin
                    run = gg[k];
                    for (int m = k + 1; m < j; m++) run = run & pp[m];
                    cc[j] = cc[j] | run;
                end
            end
            grp_p = &pp;
            grp_g = 1'b0;
            for (int k = 0; k < GRP; k++) begin
                run = gg[k];
                for (int m = k + 1; m < GRP; m++) run = run & pp[m];
                grp_g = grp_g | run;
            end
        end

        assign sp[gi*GRP +: GRP] = pp ^ cc[GRP-1:0];
        assign gc[gi+1]          = grp_g | (grp_p & gc[gi]);
    end

    assign sum = sp[W-1:0];

    if (WP > W) begin : g_pad
        assign cout = sp[W];
    end else begin : g_nopad
        assign cout = gc[NG];
    end
endmodule

// File: rtl/shiftadd_ctrl.sv
`timescale 1ns/1ps
// Control state machine: accept, N run cycles, one done cycle.
module shiftadd_ctrl
    import shiftadd_pkg::*;
#(
    parameter int N = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = cnt_width(N);
    localparam logic [CW-1:0] LAST_CNT = CW'(N - 1);

    mul_state_t    state, state_nx;
    logic [CW-1:0] iter;
    logic          accept;

    // Start is honoured only outside the run state
    assign accept = start && (state != ST_RUN);

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_RUN;          // accept
            ST_RUN:  if (iter == LAST_CNT) state_nx = ST_DONE; // finish
            ST_DONE: state_nx = accept ? ST_RUN : ST_IDLE;   // restart / retire
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                iter <= '0;
        else if (accept)           iter <= '0;
        else if (state == ST_RUN)  iter <= iter + 1'b1;
    end

    // Output decode
    always_comb begin
        load = accept;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN:  begin step = 1'b1; busy = 1'b1; end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/shiftadd_dpath.sv
`timescale 1ns/1ps
// Accumulator, multiplicand register and the shared adder.
module shiftadd_dpath #(
    parameter int N   = 32,
    parameter int GRP = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [N-1:0]   mcand_in,
    input  logic [N-1:0]   mplier_in,
    output logic [2*N-1:0] acc
);
    localparam int AW = 2 * N;

    logic [N-1:0] mcand_q;
    logic [N-1:0] addend, hi_sum;
    logic         hi_carry;

    // Add the multiplicand only when the current bottom bit is set
    assign addend = acc[0] ? mcand_q : '0;

    shiftadd_cla #(.W(N), .GRP(GRP)) u_add (
        .x    (acc[AW-1:N]),
        .y    (addend),
        .cin  (1'b0),
        .sum  (hi_sum),
        .cout (hi_carry)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            mcand_q <= '0;
        end else if (load) begin
            acc     <= {{N{1'b0}}, mplier_in};
            mcand_q <= mcand_in;
        end else if (step) begin
            acc     <= {hi_carry, hi_sum, acc[N-1:1]};
        end
    end
endmodule

// File: rtl/shiftadd_mult.sv
`timescale 1ns/1ps
// Top: N x N unsigned shift-add multiplier with a 2N-bit result.
module shiftadd_mult #(
    parameter int N   = 32,
    parameter int GRP = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   multiplicand,
    input  logic [N-1:0]   multiplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);
    logic load, step;

    shiftadd_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    shiftadd_dpath #(.N(N), .GRP(GRP)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .acc       (product)
    );
endmodule

// File: rtl/shiftadd_mult_chk.sv
`timescale 1ns/1ps
module shiftadd_mult_chk #(
    parameter int N = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [N-1:0]   multiplicand,
    input logic [N-1:0]   multiplier,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    localparam int AW = 2 * N;

    logic [N-1:0] a_q, b_q;
    int unsigned  run_cnt;
    logic [AW-1:0] ref_p;

    // Reference operands captured at each accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            run_cnt <= 0;
        end else if (start && !busy) begin
            a_q     <= multiplicand;
            b_q     <= multiplier;
            run_cnt <= 0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1;
        end
    end

    assign ref_p = AW'(a_q) * AW'(b_q);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == N));

    assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Operands of an ignored start (R3) would break this comparison
    assert_product_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == ref_p));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    assert_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind shiftadd_mult shiftadd_mult_chk #(.N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
);

// File: tb/shiftadd_mult_test.sv
`timescale 1ns/1ps
module shiftadd_mult_test;
    localparam int N  = 32;
    localparam int AW = 2 * N;
    localparam logic [N-1:0] ONES = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [N-1:0]  mcand = '0;
    logic [N-1:0]  mplier = '0;
    logic          busy, done;
    logic [AW-1:0] product;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    shiftadd_mult #(.N(N)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .multiplicand (mcand),
        .multiplier   (mplier),
        .busy         (busy),
        .done         (done),
        .product      (product)
    );

    function automatic logic [AW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        return AW'(a) * AW'(b);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One multiplication; optionally a second start mid-run (R3)
    // and a start in the done cycle (R9), which is then left running.
    task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b,
                           input bit poke, input bit chain,
                           input logic [N-1:0] a2, input logic [N-1:0] b2);
        logic [AW-1:0] exp_p;
        exp_p = ref_mul(a, b);
        @(negedge clk);
        start = 1'b1; mcand = a; mplier = b;
        @(negedge clk);
        start = 1'b0; mcand = ~a; mplier = ~b;
        check(busy === 1'b1, "R2", "busy after accept", AW'(busy), 1);
        for (int k = 1; k <= N; k++) begin
            if (poke && k == N / 2) begin
                start = 1'b1; mcand = a2; mplier = b2;
            end
            @(negedge clk);
            start = 1'b0;
            if (k < N) begin
                if (done !== 1'b0 || busy !== 1'b1) begin
                    check(1'b0, "R4", "done early or busy dropped", AW'({busy, done}), 2);
                end
            end
        end
        check(done === 1'b1, "R4", "done at cycle N", AW'(done), 1);
        check(busy === 1'b0, "R9", "busy with done", AW'(busy), 0);
        check(product === exp_p, poke ? "R3" : "R5", "product", product, exp_p);
        if (chain) begin
            start = 1'b1; mcand = a2; mplier = b2;
            @(negedge clk);
            start = 1'b0;
            check(busy === 1'b1, "R9", "restart from done", AW'(busy), 1);
            for (int k = 1; k <= N; k++) @(negedge clk);
            check(done === 1'b1 && product === ref_mul(a2, b2), "R9", "chained product",
                  product, ref_mul(a2, b2));
        end
        @(negedge clk);
        check(done === 1'b0, "R4", "done one cycle only", AW'(done), 0);
        repeat (3) @(negedge clk);
        check(product === (chain ? ref_mul(a2, b2) : exp_p), "R6", "held while idle",
              product, chain ? ref_mul(a2, b2) : exp_p);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            finish_run();
        end
    end

    initial begin
        logic [N-1:0] ra, rb;
        void'($urandom(32'd4711));
        #1;
        check(busy === 1'b0 && done === 1'b0 && product === '0, "R1", "in reset",
              product, '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && product === '0, "R1", "after reset",
              product, '0);

        // R8 corner operands
        run_mul('0, '0, 0, 0, '0, '0);
        run_mul('0, ONES, 0, 0, '0, '0);
        run_mul(ONES, N'(1), 0, 0, '0, '0);
        run_mul(N'(1), 32'h9E37_79B9, 0, 0, '0, '0);
        // R7 every cycle adds and carries
        run_mul(ONES, ONES, 0, 0, '0, '0);
        run_mul(32'h8000_0000, 32'h8000_0001, 0, 0, '0, '0);
        // R3 start while busy is ignored
        run_mul(32'h1234_5678, 32'h0BAD_F00D, 1, 0, ONES, ONES);
        // R9 back-to-back
        run_mul(32'hDEAD_BEEF, 32'hCAFE_F00D, 0, 1, ONES, 32'h0000_0003);

        for (int i = 0; i < 40; i++) begin
            ra = $urandom();
            rb = $urandom();
            if (i % 8 == 3) ra = ra | 32'hFFFF_0000;
            run_mul(ra, rb, (i % 5 == 1), (i % 7 == 2), $urandom(), $urandom());
        end
        finish_run();
    end
endmodule